// File: doc/BRIEF.md
# Raster Video Output Port Formatter

This block sits between an upstream raster generator and the pins of a digital video output port. Each pixel clock it takes one 36-bit RGB pixel (12 bits per colour) and a set of raster timing levels and events. It emits a registered stream of pixel data together with an active-video indicator, composite sync, vertical sync, a field flag and one status strobe picked from eight sources. The data path carries an extra delay chosen by a rate-range setting. The active-video indicator always changes state exactly three clocks before the matching change in the data, whatever that extra delay is.

When the luminance mode is on, a 16-bit luminance sample taken from the low bits of the pixel input is spread over the three colour fields. Every colour field then carries the eight most significant luminance bits, and the full 16-bit value can be rebuilt from red and blue. The status strobe defaults to marking every pixel of the first frame that begins after a frame-buffer swap. The swap event is latched until it is reported. A receiver-power-good input forces every output to zero. The rate range, the luminance mode and the status selection are all sampled only at a frame start.

Top module: `vid_port_fmt`

## Requirements
- R1: Pixel data leaves in input order, one pixel per clock, as red = out_red, green = out_green, blue = out_blue, taken from in_rgb[35:24], in_rgb[23:12] and in_rgb[11:0]. Data latency is 4 + E clocks, where E is the extra delay.
- R2: out_vact (high during active video) rises exactly 3 clocks before the first active pixel appears on the data outputs and falls exactly 3 clocks before the last active pixel is replaced, in every rate range.
- R3: Rate code 0 gives E = 0, code 1 gives E = 2, and codes 2 and 3 give E = 3. out_vact and the other timing outputs have a latency of 1 + E clocks.
- R4: out_csync, out_vsync and out_field follow in_csync, in_vsync and in_field with the same latency as out_vact.
- R5: With the luminance mode on, taking L = in_rgb[15:0]: red = L[15:4], green = L[15:4], blue[11:4] = L[15:8] and blue[3:0] = L[3:0]. Bits in_rgb[35:16] are ignored. With the mode off, the pixel passes unchanged.
- R6: Status select codes: 0 = first frame after swap, 1 = line start, 2 = field start, 3 = frame start, 4 = tri-level sync, 5 = request window AND pending swap, 6 = constant 1, 7 = constant 0. out_stat has the timing latency.
- R7: A swap pulse is latched. Under code 0, out_stat is high for every cycle of the next frame, from its frame-start cycle to the next frame start. A swap on the same cycle as a frame start counts for the frame after it.
- R8: A swap that arrives during the frame that is reporting an earlier swap is held and reported on the following frame. With no further swap, the frame after that reports low.
- R9: The rate, luminance and status-select settings are loaded only in a cycle with in_frame_start high, and they take effect from the next cycle. Changes at other times have no effect.
- R10: out_rsvd is always 0.
- R11: When pwr_good is low, every data and timing output is 0 from the next clock edge.
- R12: After synchronous reset every output is 0, and the settings are rate code 0, luminance off and status code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_rgb | input | 36 | Pixel: red [35:24], green [23:12], blue [11:0]; luminance on [15:0] |
| in_active | input | 1 | Active video, aligned with in_rgb |
| in_csync | input | 1 | Composite sync level |
| in_vsync | input | 1 | Vertical sync level |
| in_field | input | 1 | Field level (high in second field) |
| in_line_start | input | 1 | Line start event |
| in_field_start | input | 1 | Field start event |
| in_frame_start | input | 1 | Frame start event; loads settings |
| in_tri_sync | input | 1 | Tri-level sync level |
| in_req_win | input | 1 | Data request window |
| in_swap | input | 1 | Frame-buffer swap event |
| cfg_rate | input | 2 | Rate-range code |
| cfg_luma | input | 1 | 16-bit luminance mode |
| cfg_stat_sel | input | 3 | Status source code |
| pwr_good | input | 1 | Receiver power present |
| out_red | output | 12 | Red component |
| out_green | output | 12 | Green component |
| out_blue | output | 12 | Blue component |
| out_vact | output | 1 | Composite blank, high in active video |
| out_csync | output | 1 | Composite sync |
| out_vsync | output | 1 | Vertical sync |
| out_field | output | 1 | Field flag |
| out_stat | output | 1 | Selected status strobe |
| out_rsvd | output | 2 | Reserved, driven 0 |

## Verification
The assertions take for granted that the event inputs are one-cycle pulses and that the frame start is the only moment when the settings may move. They also take for granted that pwr_good is a clean level sampled by the pixel clock. The bench drives each event for exactly one cycle on the falling edge and changes the rate setting only in blanking, or deliberately without a frame start in order to show that such a change is ignored. Latency is measured on isolated bursts of nonzero pixels framed by zero data, so the first and last active pixels are unambiguous at the outputs.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

    localparam int COMP_W     = 12;
    localparam int LUMA_W     = 16;
    localparam int EXTRA_MID  = 2;
    localparam int EXTRA_HIGH = 3;
    localparam int BLANK_LEAD = 3;
    localparam int MAX_EXTRA  = (EXTRA_HIGH > EXTRA_MID) ? EXTRA_HIGH : EXTRA_MID;
    localparam int EXTRA_W    = $clog2(MAX_EXTRA + 1);

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] green;
        logic [COMP_W-1:0] blue;
    } vpf_pix_t;

    typedef struct packed {
        logic vact;
        logic csync;
        logic vsync;
        logic field;
        logic stat;
    } vpf_tim_t;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'd0,
        RATE_MID  = 2'd1,
        RATE_HIGH = 2'd2,
        RATE_TOP  = 2'd3
    } vpf_rate_e;

    typedef enum logic [2:0] {
        ST_SWAPFRM = 3'd0,
        ST_LINE    = 3'd1,
        ST_FIELD   = 3'd2,
        ST_FRAME   = 3'd3,
        ST_TRI     = 3'd4,
        ST_REQWIN  = 3'd5,
        ST_ONE     = 3'd6,
        ST_ZERO    = 3'd7
    } vpf_stat_e;

    function automatic logic [EXTRA_W-1:0] extra_of(input vpf_rate_e r);
        case (r)
            RATE_LOW: extra_of = '0;
            RATE_MID: extra_of = EXTRA_W'(EXTRA_MID);
            default:  extra_of = EXTRA_W'(EXTRA_HIGH);
        endcase
    endfunction

endpackage

// File: rtl/vpf_tap_delay.sv
module vpf_tap_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 3,
    parameter int SW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [SW-1:0] sel,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    logic [W-1:0] pipe [1:DEPTH];
    logic [W-1:0] tap;

    generate
        for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
            if (i == 1) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= '0;
                    else     pipe[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= '0;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    // Tap 0 is the live input; a select beyond DEPTH keeps the deepest reached.
    always_comb begin
        tap = din;
        for (int k = 1; k <= DEPTH; k++) begin
            if (int'(sel) >= k) tap = pipe[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (en) dout <= tap;
        else         dout <= '0;
    end

endmodule

// File: rtl/vpf_ctrl.sv
module vpf_ctrl
    import vpf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               field_start,
    input  logic               tri_sync,
    input  logic               req_win,
    input  logic               swap,
    input  vpf_rate_e          cfg_rate,
    input  logic               cfg_luma,
    input  vpf_stat_e          cfg_sel,
    output logic [EXTRA_W-1:0] extra,
    output logic               luma_on,
    output logic               stat
);

    vpf_rate_e rate_q;
    vpf_stat_e sel_q;
    logic      luma_q;
    logic      pend_q;
    logic      swf_q;
    logic      cur_swf;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_LOW;
            sel_q  <= ST_SWAPFRM;
            luma_q <= 1'b0;
            pend_q <= 1'b0;
            swf_q  <= 1'b0;
        end else if (frame_start) begin
            rate_q <= cfg_rate;
            sel_q  <= cfg_sel;
            luma_q <= cfg_luma;
            swf_q  <= pend_q;
            pend_q <= swap;
        end else begin
            pend_q <= pend_q | swap;
        end
    end

    // The reporting frame is marked from its own frame-start cycle onward.
    assign cur_swf = frame_start ? pend_q : swf_q;

    always_comb begin
        case (sel_q)
            ST_SWAPFRM: stat = cur_swf;
            ST_LINE:    stat = line_start;
            ST_FIELD:   stat = field_start;
            ST_FRAME:   stat = frame_start;
            ST_TRI:     stat = tri_sync;
            ST_REQWIN:  stat = req_win & pend_q;
            ST_ONE:     stat = 1'b1;
            default:    stat = 1'b0;
        endcase
    end

    assign extra   = extra_of(rate_q);
    assign luma_on = luma_q;

    p_swap_report_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start && pend_q |=> swf_q);

    p_swap_clear_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start && !swap |=> !pend_q);

    p_swap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_start && pend_q |=> pend_q);

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(rate_q) && $stable(sel_q) && $stable(luma_q));

endmodule

// File: rtl/vpf_pack.sv
module vpf_pack
    import vpf_pkg::*;
(
    input  vpf_pix_t raw,
    input  logic     luma_on,
    output vpf_pix_t pix
);

    localparam int LSB_W = LUMA_W - COMP_W;
    localparam int HI_W  = COMP_W - LSB_W;

    logic [LUMA_W-1:0] lum;

    assign lum = raw[LUMA_W-1:0];

    always_comb begin
        if (luma_on) begin
            pix.red   = lum[LUMA_W-1 -: COMP_W];
            pix.green = lum[LUMA_W-1 -: COMP_W];
            pix.blue  = {lum[LUMA_W-1 -: HI_W], lum[LSB_W-1:0]};
        end else begin
            pix = raw;
        end
    end

    always_comb begin
        if (luma_on) begin
            p_luma_dup_r5: assert (pix.red == pix.green &&
                                   pix.blue[COMP_W-1 -: HI_W] == pix.red[COMP_W-1 -: HI_W]);
        end
    end

endmodule

// File: rtl/vid_port_fmt.sv
module vid_port_fmt
    import vpf_pkg::*;
#(
    parameter int LEAD = BLANK_LEAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [35:0]       in_rgb,
    input  logic              in_active,
    input  logic              in_csync,
    input  logic              in_vsync,
    input  logic              in_field,
    input  logic              in_line_start,
    input  logic              in_field_start,
    input  logic              in_frame_start,
    input  logic              in_tri_sync,
    input  logic              in_req_win,
    input  logic              in_swap,
    input  logic [1:0]        cfg_rate,
    input  logic              cfg_luma,
    input  logic [2:0]        cfg_stat_sel,
    input  logic              pwr_good,
    output logic [COMP_W-1:0] out_red,
    output logic [COMP_W-1:0] out_green,
    output logic [COMP_W-1:0] out_blue,
    output logic              out_vact,
    output logic              out_csync,
    output logic              out_vsync,
    output logic              out_field,
    output logic              out_stat,
    output logic [1:0]        out_rsvd
);

    localparam int DATA_DEPTH = LEAD + MAX_EXTRA;
    localparam int TIM_DEPTH  = MAX_EXTRA;
    localparam int DSW        = $clog2(DATA_DEPTH + 1);
    localparam int TSW        = $clog2(TIM_DEPTH + 1);

    logic [EXTRA_W-1:0] extra;
    logic               luma_on;
    logic               stat_now;
    vpf_pix_t           pix_raw;
    vpf_pix_t           pix_in;
    vpf_pix_t           pix_out;
    vpf_tim_t           tim_in;
    vpf_tim_t           tim_out;
    logic [DSW-1:0]     data_sel;
    logic [TSW-1:0]     tim_sel;

    vpf_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .frame_start (in_frame_start),
        .line_start  (in_line_start),
        .field_start (in_field_start),
        .tri_sync    (in_tri_sync),
        .req_win     (in_req_win),
        .swap        (in_swap),
        .cfg_rate    (vpf_rate_e'(cfg_rate)),
        .cfg_luma    (cfg_luma),
        .cfg_sel     (vpf_stat_e'(cfg_stat_sel)),
        .extra       (extra),
        .luma_on     (luma_on),
        .stat        (stat_now)
    );

    assign pix_raw = vpf_pix_t'(in_rgb);

    vpf_pack u_pack (
        .raw     (pix_raw),
        .luma_on (luma_on),
        .pix     (pix_in)
    );

    always_comb begin
        tim_in.vact  = in_active;
        tim_in.csync = in_csync;
        tim_in.vsync = in_vsync;
        tim_in.field = in_field;
        tim_in.stat  = stat_now;
    end

    // Data sits LEAD taps deeper than timing, so the lead is range-independent.
    assign data_sel = DSW'(LEAD) + DSW'(extra);
    assign tim_sel  = TSW'(extra);

    vpf_tap_delay #(.W($bits(vpf_pix_t)), .DEPTH(DATA_DEPTH)) u_data_dly (
        .clk  (clk),
        .rst  (rst),
        .en   (pwr_good),
        .sel  (data_sel),
        .din  (pix_in),
        .dout (pix_out)
    );

    vpf_tap_delay #(.W($bits(vpf_tim_t)), .DEPTH(TIM_DEPTH)) u_tim_dly (
        .clk  (clk),
        .rst  (rst),
        .en   (pwr_good),
        .sel  (tim_sel),
        .din  (tim_in),
        .dout (tim_out)
    );

    assign out_red   = pix_out.red;
    assign out_green = pix_out.green;
    assign out_blue  = pix_out.blue;
    assign out_vact  = tim_out.vact;
    assign out_csync = tim_out.csync;
    assign out_vsync = tim_out.vsync;
    assign out_field = tim_out.field;
    assign out_stat  = tim_out.stat;
    assign out_rsvd  = 2'b00;

    p_pwr_off_r11: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (out_red == '0 && out_green == '0 && out_blue == '0 &&
                       !out_vact && !out_csync && !out_vsync && !out_field && !out_stat));

endmodule

// File: tb/vid_port_fmt_test.sv
module vid_port_fmt_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [35:0] in_rgb;
    logic        in_active, in_csync, in_vsync, in_field;
    logic        in_line_start, in_field_start, in_frame_start;
    logic        in_tri_sync, in_req_win, in_swap;
    logic [1:0]  cfg_rate;
    logic        cfg_luma;
    logic [2:0]  cfg_stat_sel;
    logic        pwr_good;
    logic [11:0] out_red, out_green, out_blue;
    logic        out_vact, out_csync, out_vsync, out_field, out_stat;
    logic [1:0]  out_rsvd;

    int n_chk  = 0;
    int n_fail = 0;

    logic        obs_v [0:31];
    logic [35:0] obs_d [0:31];

    always #(CLK_P/2) clk = ~clk;

    vid_port_fmt uut (
        .clk(clk), .rst(rst), .in_rgb(in_rgb), .in_active(in_active),
        .in_csync(in_csync), .in_vsync(in_vsync), .in_field(in_field),
        .in_line_start(in_line_start), .in_field_start(in_field_start),
        .in_frame_start(in_frame_start), .in_tri_sync(in_tri_sync),
        .in_req_win(in_req_win), .in_swap(in_swap), .cfg_rate(cfg_rate),
        .cfg_luma(cfg_luma), .cfg_stat_sel(cfg_stat_sel), .pwr_good(pwr_good),
        .out_red(out_red), .out_green(out_green), .out_blue(out_blue),
        .out_vact(out_vact), .out_csync(out_csync), .out_vsync(out_vsync),
        .out_field(out_field), .out_stat(out_stat), .out_rsvd(out_rsvd)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        in_rgb = '0; in_active = 0; in_csync = 0; in_vsync = 0; in_field = 0;
        in_line_start = 0; in_field_start = 0; in_frame_start = 0;
        in_tri_sync = 0; in_req_win = 0; in_swap = 0;
    endtask

    task automatic load_cfg(input logic [1:0] r, input logic l, input logic [2:0] s);
        cfg_rate = r; cfg_luma = l; cfg_stat_sel = s;
        in_frame_start = 1;
        tick();
        in_frame_start = 0;
        tick(8);
    endtask

    function automatic logic [35:0] pix(input int c);
        return {12'h100 + 12'(c), 12'h200 + 12'(c), 12'h300 + 12'(c)};
    endfunction

    // Burst of active pixels at input cycles 2..6, then measure edges.
    task automatic run_lat(input int e, input string tag);
        int fb = -1, lb = -1, fd = -1, ld = -1;
        for (int c = 0; c < 24; c++) begin
            idle();
            if (c >= 2 && c < 7) begin
                in_active = 1;
                in_rgb    = pix(c);
            end
            tick();
            obs_v[c+1] = out_vact;
            obs_d[c+1] = {out_red, out_green, out_blue};
        end
        idle();
        for (int k = 1; k <= 24; k++) begin
            if (obs_v[k] && fb < 0) fb = k;
            if (obs_v[k]) lb = k;
            if (obs_d[k] != '0 && fd < 0) fd = k;
            if (obs_d[k] != '0) ld = k;
        end
        chk(tag, "blank rise cycle", 64'(fb), 64'(2 + 1 + e));
        chk("R2", "lead at start", 64'(fd - fb), 64'd3);
        chk("R2", "lead at end", 64'(ld - lb), 64'd3);
        chk("R1", "first pixel", 64'(obs_d[2 + 4 + e]), 64'(pix(2)));
        chk("R1", "last pixel", 64'(obs_d[6 + 4 + e]), 64'(pix(6)));
    endtask

    task automatic t_reset();
        chk("R12", "data after reset", 64'({out_red, out_green, out_blue}), 64'd0);
        chk("R12", "timing after reset",
            64'({out_vact, out_csync, out_vsync, out_field, out_stat}), 64'd0);
        chk("R10", "reserved after reset", 64'(out_rsvd), 64'd0);
        // default rate: E = 0
        run_lat(0, "R12");
    endtask

    task automatic t_latency();
        load_cfg(2'd0, 0, 3'd7); run_lat(0, "R3");
        load_cfg(2'd1, 0, 3'd7); run_lat(2, "R3");
        load_cfg(2'd2, 0, 3'd7); run_lat(3, "R3");
        load_cfg(2'd3, 0, 3'd7); run_lat(3, "R3");
    endtask

    task automatic t_sync();
        load_cfg(2'd2, 0, 3'd7);
        in_csync = 1; in_vsync = 1; in_field = 1;
        tick();
        idle();
        tick(2);
        chk("R4", "sync early", 64'({out_csync, out_vsync, out_field}), 64'd0);
        tick();
        chk("R4", "sync at 1+E", 64'({out_csync, out_vsync, out_field}), 64'h7);
        tick();
        chk("R4", "sync after", 64'({out_csync, out_vsync, out_field}), 64'd0);
    endtask

    task automatic t_luma();
        load_cfg(2'd0, 1, 3'd7);
        in_active = 1; in_rgb = 36'h12345ABCD;
        tick();
        idle();
        tick(3);
        chk("R5", "luma red", 64'(out_red), 64'hABC);
        chk("R5", "luma green", 64'(out_green), 64'hABC);
        chk("R5", "luma blue", 64'(out_blue), 64'hABD);
        load_cfg(2'd0, 0, 3'd7);
        in_active = 1; in_rgb = 36'h12345ABCD;
        tick();
        idle();
        tick(3);
        chk("R5", "raw pass", 64'({out_red, out_green, out_blue}), 64'h12345ABCD);
    endtask

    task automatic t_stat_pulse(input logic [2:0] s);
        load_cfg(2'd0, 0, s);
        case (s)
            3'd1: in_line_start = 1;
            3'd2: in_field_start = 1;
            3'd3: in_frame_start = 1;
            default: in_tri_sync = 1;
        endcase
        tick();
        idle();
        chk("R6", $sformatf("stat code %0d on", s), 64'(out_stat), 64'd1);
        tick();
        chk("R6", $sformatf("stat code %0d off", s), 64'(out_stat), 64'd0);
    endtask

    task automatic t_status();
        t_stat_pulse(3'd1);
        t_stat_pulse(3'd2);
        t_stat_pulse(3'd3);
        t_stat_pulse(3'd4);
        load_cfg(2'd0, 0, 3'd6);
        chk("R6", "const one", 64'(out_stat), 64'd1);
        load_cfg(2'd0, 0, 3'd7);
        in_line_start = 1; in_tri_sync = 1; in_req_win = 1;
        tick();
        idle();
        chk("R6", "const zero", 64'(out_stat), 64'd0);
    endtask

    task automatic frame_pulse(input logic with_swap);
        in_frame_start = 1; in_swap = with_swap;
        tick();
        idle();
    endtask

    task automatic t_swap();
        load_cfg(2'd0, 0, 3'd0);
        chk("R7", "no swap yet", 64'(out_stat), 64'd0);
        in_swap = 1; tick(); idle(); tick(3);
        chk("R7", "swap not before frame", 64'(out_stat), 64'd0);
        frame_pulse(0);
        chk("R7", "report at frame start", 64'(out_stat), 64'd1);
        tick(3);
        chk("R7", "report through frame", 64'(out_stat), 64'd1);
        in_swap = 1; tick(); idle(); tick(2);
        frame_pulse(0);
        chk("R8", "held swap reported", 64'(out_stat), 64'd1);
        tick(2);
        chk("R8", "held swap frame", 64'(out_stat), 64'd1);
        frame_pulse(0);
        chk("R8", "cleared after report", 64'(out_stat), 64'd0);
        frame_pulse(1);
        chk("R7", "coincident swap waits", 64'(out_stat), 64'd0);
        tick(2);
        frame_pulse(0);
        chk("R7", "coincident swap next", 64'(out_stat), 64'd1);
        frame_pulse(0);
        // request window gated by pending swap
        load_cfg(2'd0, 0, 3'd5);
        in_req_win = 1; tick();
        chk("R6", "window without swap", 64'(out_stat), 64'd0);
        in_swap = 1; tick(); in_swap = 0; tick();
        chk("R6", "window with swap", 64'(out_stat), 64'd1);
        in_req_win = 0; tick();
        chk("R6", "window closed", 64'(out_stat), 64'd0);
        idle();
        frame_pulse(0);
    endtask

    task automatic t_boundary();
        load_cfg(2'd0, 0, 3'd7);
        cfg_rate = 2'd2; cfg_luma = 1; cfg_stat_sel = 3'd6;
        tick(2);
        chk("R9", "sel ignored mid frame", 64'(out_stat), 64'd0);
        run_lat(0, "R9");
        in_active = 1; in_rgb = 36'h12345ABCD;
        tick(); idle(); tick(3);
        chk("R9", "luma ignored mid frame", 64'({out_red, out_green, out_blue}),
            64'h12345ABCD);
    endtask

    task automatic t_power();
        load_cfg(2'd0, 0, 3'd6);
        pwr_good = 0;
        in_active = 1; in_rgb = 36'hFFFFFFFFF; in_csync = 1; in_vsync = 1; in_field = 1;
        tick(6);
        chk("R11", "data off", 64'({out_red, out_green, out_blue}), 64'd0);
        chk("R11", "timing off",
            64'({out_vact, out_csync, out_vsync, out_field, out_stat}), 64'd0);
        pwr_good = 1;
        tick();
        chk("R11", "timing restored",
            64'({out_vact, out_csync, out_vsync, out_field, out_stat}), 64'h1F);
        idle();
        tick(8);
        chk("R10", "reserved at end", 64'(out_rsvd), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst = 1; pwr_good = 1;
        cfg_rate = 2'd0; cfg_luma = 0; cfg_stat_sel = 3'd7;
        tick(4);
        rst = 0;
        tick();
        t_reset();
        t_latency();
        t_sync();
        t_luma();
        t_status();
        t_swap();
        t_boundary();
        t_power();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule